// File: doc/BRIEF.md
# Segmented Converter Code Decoder

This block turns signed audio samples into the digital controls of a three-segment converter. Each sample is recoded from two's complement to offset binary and split into three fields. The upper field selects a tap on a resistor string. The middle field sets, by pulse-width modulation, how many time slots use the upper of the two neighbouring taps. The low field drives a pair of trim codes whose sum does not change. The analog parts are not modelled.

The clock runs at eight slots per sample period, so one period of the pulse-width stage is one sample. Samples for all channels arrive together on one strobe. Each channel holds the latest sample as pending and applies it only at the start of the next period, so the three fields of a code always change together. An active-low initialisation input and a synchronous reset both drive every channel to the zero (midscale) level.

Top module: `seg_dac_decoder`

## Requirements
- R1: `tap_idx` of a channel equals the upper 9 bits of its active sample after the sample MSB (bit 17) is inverted. Input 0 gives 256, 0x1FFFF gives 511, 0x20000 gives 0 and 0x3FFFF gives 255.
- R2: Let N be bits [8:6] of the active sample. Within a period, slots are numbered 0 to 7, and `tap_up` of that channel is 1 in slots 0 to N-1 and 0 in the remaining slots. N=0 keeps it low for the whole period and N=7 keeps it low only in slot 7.
- R3: `trim_lo` of a channel equals bits [5:0] of the active sample.
- R4: `trim_hi` equals 63 minus `trim_lo`, so the two codes always sum to 63.
- R5: A period is 8 clock cycles. The cycle after the last reset edge is slot 0. A strobe captured in slots 0 to 6 becomes active at the start of the next period. A strobe captured in slot 7 becomes active one period later. Outputs do not change in the middle of a period.
- R6: When several strobes fall within one period, only the last one is used.
- R7: While `init_n` is low, every channel shows midscale from the next clock edge on: `tap_idx`=256, `tap_up`=0, `trim_lo`=0 and `trim_hi`=63. Strobes are ignored while it is low, and any pending sample is discarded. The slot count keeps running.
- R8: `rst` is synchronous and active high. It sets every channel to midscale, clears pending samples and restarts the slot count at slot 0.
- R9: Channel c takes its sample from `smp_data[c*18 +: 18]` and drives field c of each output. The channels are otherwise independent.
- R10: If no strobe arrives, the active code repeats in every period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, 8 cycles per sample period |
| rst | input | 1 | Synchronous active-high reset |
| init_n | input | 1 | Active-low initialisation, forces midscale |
| smp_stb | input | 1 | Captures `smp_data` for all channels |
| smp_data | input | NCH*18 | Two's-complement samples, channel 0 in the low bits |
| tap_idx | output | NCH*9 | Resistor-string tap per channel |
| tap_up | output | NCH | 1 selects the upper neighbouring tap, 0 the lower |
| trim_lo | output | NCH*6 | Lower trim code per channel |
| trim_hi | output | NCH*6 | Upper trim code per channel |

## Verification
The assertions assume that `rst` is held high over the first clock edges, so that the slot count and the outputs start from a known value. They also assume that `init_n` and `smp_stb` are sampled only at clock edges. The bench changes every input at the falling edge only. It asserts reset for several cycles at the start and again, briefly, at random points later in the run. It holds `init_n` low only for whole cycles. Strobes land on every slot, including the last slot of a period, so the deferred case is covered.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;
  localparam int DEF_CODE_W = 18;
  localparam int DEF_TAP_W  = 9;
  localparam int DEF_PWM_W  = 3;
  localparam int DEF_NCH    = 2;
endpackage

// File: rtl/seg_slot_counter.sv
module seg_slot_counter #(
  parameter int PWM_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  output logic [PWM_W-1:0] slot_q,
  output logic [PWM_W-1:0] slot_nxt,
  output logic             period_end
);
  localparam logic [PWM_W-1:0] LAST = '1;

  // free-running slot index; wraps at the width limit
  always_ff @(posedge clk) begin
    if (rst) slot_q <= '0;
    else     slot_q <= slot_nxt;
  end

  always_comb begin
    slot_nxt   = slot_q + PWM_W'(1);
    period_end = (slot_q == LAST);
  end
endmodule

// File: rtl/seg_dac_chan.sv
module seg_dac_chan #(
  parameter int CODE_W = 18,
  parameter int TAP_W  = 9,
  parameter int PWM_W  = 3,
  parameter int LS_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_n,
  input  logic              stb,
  input  logic [CODE_W-1:0] data_in,
  input  logic              period_end,
  input  logic [PWM_W-1:0]  slot_nxt,
  output logic [TAP_W-1:0]  tap_o,
  output logic              up_o,
  output logic [LS_W-1:0]   lo_o,
  output logic [LS_W-1:0]   hi_o
);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  logic [CODE_W-1:0] pend_q, act_q, act_d, obin;
  logic              up_q;
  logic [LS_W-1:0]   hi_q;

  always_comb begin
    // offset binary: flip the sign bit
    obin  = {~data_in[CODE_W-1], data_in[CODE_W-2:0]};
    // the active code is swapped only at a period boundary
    act_d = period_end ? pend_q : act_q;
  end

  always_ff @(posedge clk) begin
    if (rst || !init_n) begin
      pend_q <= MID;
      act_q  <= MID;
      up_q   <= 1'b0;
      hi_q   <= '1;
    end else begin
      if (stb) pend_q <= obin;
      act_q <= act_d;
      up_q  <= (slot_nxt < act_d[LS_W +: PWM_W]);
      hi_q  <= ~act_d[LS_W-1:0];
    end
  end

  assign tap_o = act_q[CODE_W-1 -: TAP_W];
  assign up_o  = up_q;
  assign lo_o  = act_q[LS_W-1:0];
  assign hi_o  = hi_q;
endmodule

// File: rtl/seg_dac_decoder.sv
module seg_dac_decoder
  import seg_dac_pkg::*;
#(
  parameter int CODE_W = DEF_CODE_W,
  parameter int TAP_W  = DEF_TAP_W,
  parameter int PWM_W  = DEF_PWM_W,
  parameter int NCH    = DEF_NCH,
  parameter int LS_W   = CODE_W - TAP_W - PWM_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  init_n,
  input  logic                  smp_stb,
  input  logic [NCH*CODE_W-1:0] smp_data,
  output logic [NCH*TAP_W-1:0]  tap_idx,
  output logic [NCH-1:0]        tap_up,
  output logic [NCH*LS_W-1:0]   trim_lo,
  output logic [NCH*LS_W-1:0]   trim_hi
);
  logic [PWM_W-1:0] slot_q, slot_nxt;
  logic             period_end;

  seg_slot_counter #(.PWM_W(PWM_W)) u_slot (
    .clk(clk), .rst(rst), .slot_q(slot_q), .slot_nxt(slot_nxt),
    .period_end(period_end)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    seg_dac_chan #(
      .CODE_W(CODE_W), .TAP_W(TAP_W), .PWM_W(PWM_W), .LS_W(LS_W)
    ) u_chan (
      .clk(clk), .rst(rst), .init_n(init_n), .stb(smp_stb),
      .data_in(smp_data[c*CODE_W +: CODE_W]),
      .period_end(period_end), .slot_nxt(slot_nxt),
      .tap_o(tap_idx[c*TAP_W +: TAP_W]), .up_o(tap_up[c]),
      .lo_o(trim_lo[c*LS_W +: LS_W]), .hi_o(trim_hi[c*LS_W +: LS_W])
    );
  end
endmodule

// File: rtl/seg_dac_decoder_chk.sv
module seg_dac_decoder_chk #(
  parameter int TAP_W = 9,
  parameter int PWM_W = 3,
  parameter int NCH   = 2,
  parameter int LS_W  = 6
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 init_n,
  input logic [PWM_W-1:0]     slot_q,
  input logic [NCH*TAP_W-1:0] tap_idx,
  input logic [NCH-1:0]       tap_up,
  input logic [NCH*LS_W-1:0]  trim_lo,
  input logic [NCH*LS_W-1:0]  trim_hi
);
  localparam logic [PWM_W-1:0] LAST    = '1;
  localparam logic [TAP_W-1:0] TAP_MID = {1'b1, {(TAP_W-1){1'b0}}};
  localparam logic [LS_W:0]    LS_SUM  = {1'b0, {LS_W{1'b1}}};

  for (genvar c = 0; c < NCH; c++) begin : g_a
    assert_trim_sum_R4: assert property (@(posedge clk) disable iff (rst)
      ({1'b0, trim_lo[c*LS_W +: LS_W]} + {1'b0, trim_hi[c*LS_W +: LS_W]}) == LS_SUM);

    assert_tap_at_boundary_R5: assert property (@(posedge clk) disable iff (rst)
      !$stable(tap_idx[c*TAP_W +: TAP_W]) |->
        ($past(slot_q) == LAST || !$past(init_n) || $past(rst)));

    assert_up_stays_low_R2: assert property (@(posedge clk) disable iff (rst)
      (!tap_up[c] && slot_q != LAST) |=> !tap_up[c]);

    assert_init_mid_R7: assert property (@(posedge clk) disable iff (rst)
      !$past(init_n) |->
        (tap_idx[c*TAP_W +: TAP_W] == TAP_MID && !tap_up[c] &&
         trim_lo[c*LS_W +: LS_W] == '0));

    assert_reset_mid_R8: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (tap_idx[c*TAP_W +: TAP_W] == TAP_MID && !tap_up[c] && slot_q == '0));
  end
endmodule

bind seg_dac_decoder seg_dac_decoder_chk #(
  .TAP_W(TAP_W), .PWM_W(PWM_W), .NCH(NCH), .LS_W(LS_W)
) u_chk (
  .clk(clk), .rst(rst), .init_n(init_n), .slot_q(slot_q),
  .tap_idx(tap_idx), .tap_up(tap_up), .trim_lo(trim_lo), .trim_hi(trim_hi)
);

// File: tb/seg_dac_decoder_test.sv
`timescale 1ns/1ps
module seg_dac_decoder_test;
  localparam int CW = 18, TW = 9, PW = 3, LW = 6, NC = 2, SL = 8;
  localparam logic [CW-1:0] MID = 18'h20000;

  logic clk = 0, rst = 1, init_n = 1, smp_stb = 0;
  logic [NC*CW-1:0] smp_data = '0;
  logic [NC*TW-1:0] tap_idx;
  logic [NC-1:0]    tap_up;
  logic [NC*LW-1:0] trim_lo, trim_hi;

  seg_dac_decoder uut (
    .clk(clk), .rst(rst), .init_n(init_n), .smp_stb(smp_stb), .smp_data(smp_data),
    .tap_idx(tap_idx), .tap_up(tap_up), .trim_lo(trim_lo), .trim_hi(trim_hi)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string cur_req = "R8";
  int m_cnt = 0;
  logic [CW-1:0] m_pend [NC];
  logic [CW-1:0] m_act  [NC];

  function automatic logic [CW-1:0] to_obin(logic [CW-1:0] s);
    return {~s[CW-1], s[CW-2:0]};
  endfunction

  // build a two's-complement sample from the three offset-binary fields
  function automatic logic [CW-1:0] mk(int t, int p, int l);
    logic [CW-1:0] o;
    o = {TW'(t), PW'(p), LW'(l)};
    return {~o[CW-1], o[CW-2:0]};
  endfunction

  function automatic logic [NC*CW-1:0] pk(logic [CW-1:0] a, logic [CW-1:0] b);
    return {b, a};
  endfunction

  task automatic chk(string fld, int ch, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s ch%0d act=%0d exp=%0d", cur_req, fld, ch, act, exp);
    end
  endtask

  task automatic compare();
    for (int c = 0; c < NC; c++) begin
      int lo;
      lo = int'(m_act[c][LW-1:0]);
      chk("tap R1", c, int'(tap_idx[c*TW +: TW]), int'(m_act[c][CW-1 -: TW]));
      chk("up R2",  c, int'(tap_up[c]), (m_cnt < int'(m_act[c][LW +: PW])) ? 1 : 0);
      chk("lo R3",  c, int'(trim_lo[c*LW +: LW]), lo);
      chk("hi R4",  c, int'(trim_hi[c*LW +: LW]), 63 - lo);
    end
  endtask

  task automatic step(logic r, logic ini, logic st, logic [NC*CW-1:0] d);
    @(negedge clk);
    rst = r; init_n = ini; smp_stb = st; smp_data = d;
    @(posedge clk);
    if (r) begin
      m_cnt = 0;
      for (int c = 0; c < NC; c++) begin m_pend[c] = MID; m_act[c] = MID; end
    end else begin
      for (int c = 0; c < NC; c++) begin
        if (!ini) begin
          m_pend[c] = MID; m_act[c] = MID;
        end else begin
          if (m_cnt == SL-1) m_act[c] = m_pend[c];
          if (st) m_pend[c] = to_obin(d[c*CW +: CW]);
        end
      end
      m_cnt = (m_cnt + 1) % SL;
    end
    #1 compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 1, 0, '0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL %s watchdog act=hung exp=done", cur_req);
      summary();
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NC; c++) begin m_pend[c] = MID; m_act[c] = MID; end
    void'($urandom(32'd4711));

    // R8: reset state is midscale
    cur_req = "R8";
    for (int i = 0; i < 3; i++) step(1, 1, 0, '0);
    idle(2);

    // R1: sign-bit recoding at extremes
    cur_req = "R1";
    step(0, 1, 1, pk(18'h00000, 18'h1FFFF)); idle(16);
    step(0, 1, 1, pk(18'h20000, 18'h3FFFF)); idle(16);

    // R2/R3: every duty value, varied trim codes
    cur_req = "R2";
    for (int n = 0; n < 8; n++) begin
      step(0, 1, 1, pk(mk(5, n, n*7), mk(300, 7-n, 63-n))); idle(15);
    end

    // R5: strobe landing in the last slot of a period is deferred
    cur_req = "R5";
    while (m_cnt != SL-1) idle(1);
    step(0, 1, 1, pk(mk(17, 4, 9), mk(400, 2, 40))); idle(18);
    while (m_cnt != 2) idle(1);
    step(0, 1, 1, pk(mk(99, 6, 1), mk(1, 3, 62))); idle(12);

    // R6: last strobe in a period wins
    cur_req = "R6";
    while (m_cnt != 1) idle(1);
    step(0, 1, 1, pk(mk(10, 1, 1), mk(20, 2, 2))); idle(2);
    step(0, 1, 1, pk(mk(30, 5, 33), mk(40, 6, 44))); idle(16);

    // R7: init forces midscale and drops pending and incoming samples
    cur_req = "R7";
    step(0, 1, 1, pk(mk(200, 3, 3), mk(201, 4, 4))); idle(3);
    for (int i = 0; i < 5; i++) step(0, 0, 1, pk(mk(77, 7, 7), mk(78, 7, 8)));
    idle(20);

    // R8: reset in mid-run
    cur_req = "R8";
    step(0, 1, 1, pk(mk(450, 5, 50), mk(451, 6, 51))); idle(12);
    step(1, 1, 0, '0); step(1, 1, 1, pk(mk(3, 3, 3), mk(4, 4, 4)));
    idle(12);

    // R10: code repeats with no strobe
    cur_req = "R10";
    step(0, 1, 1, pk(mk(123, 3, 21), mk(321, 5, 12))); idle(32);

    // R9: random independent channels
    cur_req = "R9";
    for (int i = 0; i < 700; i++) begin
      logic r, ini, st;
      r   = ($urandom % 200) == 0;
      ini = ($urandom % 50) != 0;
      st  = ($urandom % 3) == 0;
      step(r, ini, st, {NC*CW{1'b0}} | {18'($urandom), 18'($urandom)});
    end

    done = 1;
    summary();
    $finish;
  end
endmodule